// File: doc/BRIEF.md
# Seconds-Based Watchdog Timer with Reset Pulse

This block is a byte-wide watchdog timer reached through a simple register port (address, write data, write strobe, read data). Three byte registers hold its state: a count register, a control register and a status register. Writing a nonzero value to the count register loads the remaining time and starts the countdown. Writing zero stops the watchdog. Rewriting a nonzero value while it runs restarts the countdown, which serves as the keep-alive. Reading the count register returns the time left.

Each pulse on the one-second tick input takes one unit off the count. In minute mode a unit is sixty ticks. When the count steps from one to zero, the block latches a trigger flag in the status register and holds the active-low timeout output low until software clears the flag. If control enables it, the block also drives a single-clock low pulse on the keyboard-reset output. Keyboard and mouse activity inputs can be allowed to cancel a running watchdog. Tick generation and pin routing are left to the surrounding chip.

Top module: `sec_watchdog`

## Requirements
- R1: Writing 0x00 to the count register (address 0xF6) stops the watchdog. The count stays 0, further ticks have no effect, and no timeout occurs.
- R2: Writing a nonzero value N to the count register loads N and arms the watchdog. A write while it is running reloads the count (keep-alive).
- R3: Reading address 0xF6 returns the remaining count. The count drops by exactly one on each unit tick while it is nonzero.
- R4: The control register (address 0xF5) and the status register (address 0xF7) read back what was written, except for status bit 4. Any other address reads 0x00.
- R5: When the count steps from 1 to 0 on a unit tick, status bit 4 is set in that same clock edge. `wdt_out_n` goes low and stays low until bit 4 is cleared.
- R6: If control bit 1 is set at expiry, `kbrst_n` is low for exactly one clock, in the cycle after the expiring edge. If control bit 1 is clear, `kbrst_n` stays high.
- R7: Writing status with bit 4 = 0 clears the trigger and releases `wdt_out_n`. Writing bit 4 = 1 leaves the trigger unchanged.
- R8: A `kbd_evt` pulse clears a running count to 0 when control bit 2 or status bit 7 is set. A `mouse_evt` pulse clears it when status bit 6 is set. With these bits clear, the events are ignored.
- R9: After reset, all three registers read 0x00, `wdt_out_n` is 1 and `kbrst_n` is 1.
- R10: With control bit 3 set, one unit is 60 ticks. Writing the count register restarts that 60-tick division.
- R11: A count-register write in the same cycle as a unit tick or a cancel event takes priority: the written value is loaded and no expiry occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| kbd_evt | input | 1 | Keyboard activity pulse |
| mouse_evt | input | 1 | Mouse activity pulse |
| wdt_out_n | output | 1 | Active-low timeout output |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The countdown is swept for every load value from 1 to 12, and the count and timeout output are checked after each tick. This shows whether the block decrements by one per tick and fires exactly on the step from 1 to 0, and not one tick early or late. Separate patterns cover the following:
- stopping by writing zero;
- keep-alive reloads in mid-count;
- each cancel source, both enabled and disabled;
- the keyboard-reset pulse with its enable on and off;
- a write colliding with a tick.

Minute mode is driven through 59, 60 and 120 ticks, which separates the 60-tick divider from a wrong divisor or a divider that does not restart.

// File: rtl/sec_wdt_pkg.sv
package sec_wdt_pkg;
    // control register bits
    localparam int CTL_PULSE_BIT = 1;
    localparam int CTL_KCAN_BIT  = 2;
    localparam int CTL_MIN_BIT   = 3;
    // status register bits
    localparam int ST_TRIG_BIT   = 4;
    localparam int ST_MCAN_BIT   = 6;
    localparam int ST_KCAN_BIT   = 7;

    typedef struct packed {
        logic [7:0] count;
        logic [7:0] ctrl;
        logic [7:0] stat;
        logic       kbrst;
    } wdt_state_t;
endpackage

// File: rtl/sec_wdt_unit_div.sv
module sec_wdt_unit_div #(
    parameter int TICKS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic minute_mode,
    input  logic run,
    input  logic restart,
    output logic unit_tick
);
    localparam int PW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS - 1);

    logic [PW-1:0] pre_d, pre_q;
    logic          wrap;

    assign wrap = (pre_q == LAST);

    always_comb begin
        pre_d = pre_q;
        if (restart || !minute_mode) begin
            pre_d = '0;
        end else if (run && sec_tick) begin
            pre_d = wrap ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign unit_tick = minute_mode ? (sec_tick && run && wrap) : sec_tick;
endmodule

// File: rtl/sec_wdt_rdmux.sv
module sec_wdt_rdmux #(
    parameter int          AW        = 8,
    parameter int          DW        = 8,
    parameter logic [AW-1:0] CNT_ADDR  = 'hF6,
    parameter logic [AW-1:0] CTRL_ADDR = 'hF5,
    parameter logic [AW-1:0] STAT_ADDR = 'hF7
) (
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] count,
    input  logic [DW-1:0] ctrl,
    input  logic [DW-1:0] stat,
    output logic [DW-1:0] rdata
);
    always_comb begin
        unique case (addr)
            CNT_ADDR:  rdata = count;
            CTRL_ADDR: rdata = ctrl;
            STAT_ADDR: rdata = stat;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog
    import sec_wdt_pkg::*;
#(
    parameter int          AW            = 8,
    parameter int          DW            = 8,
    parameter int          TICKS_PER_MIN = 60,
    parameter logic [AW-1:0] CNT_ADDR      = 'hF6,
    parameter logic [AW-1:0] CTRL_ADDR     = 'hF5,
    parameter logic [AW-1:0] STAT_ADDR     = 'hF7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_wr,
    output logic [DW-1:0] reg_rdata,
    input  logic          sec_tick,
    input  logic          kbd_evt,
    input  logic          mouse_evt,
    output logic          wdt_out_n,
    output logic          kbrst_n
);
    wdt_state_t st_d, st_q;

    logic wr_cnt, wr_ctrl, wr_stat;
    logic running, unit_tick, cancel, expire;

    assign wr_cnt  = reg_wr && (reg_addr == CNT_ADDR);
    assign wr_ctrl = reg_wr && (reg_addr == CTRL_ADDR);
    assign wr_stat = reg_wr && (reg_addr == STAT_ADDR);
    assign running = (st_q.count != '0);

    sec_wdt_unit_div #(.TICKS(TICKS_PER_MIN)) div_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_tick    (sec_tick),
        .minute_mode (st_q.ctrl[CTL_MIN_BIT]),
        .run         (running),
        .restart     (wr_cnt),
        .unit_tick   (unit_tick)
    );

    assign cancel = running &&
        ((kbd_evt && (st_q.ctrl[CTL_KCAN_BIT] || st_q.stat[ST_KCAN_BIT])) ||
         (mouse_evt && st_q.stat[ST_MCAN_BIT]));

    assign expire = (st_q.count == DW'(1)) && unit_tick && !cancel && !wr_cnt;

    always_comb begin
        st_d       = st_q;
        st_d.kbrst = 1'b0;
        if (running) begin
            if (cancel)         st_d.count = '0;
            else if (unit_tick) st_d.count = st_q.count - 1'b1;
        end
        if (wr_cnt)  st_d.count = reg_wdata;
        if (wr_ctrl) st_d.ctrl  = reg_wdata;
        if (wr_stat) begin
            st_d.stat              = reg_wdata;
            st_d.stat[ST_TRIG_BIT] = reg_wdata[ST_TRIG_BIT] & st_q.stat[ST_TRIG_BIT];
        end
        if (expire) begin
            st_d.stat[ST_TRIG_BIT] = 1'b1;
            st_d.kbrst             = st_q.ctrl[CTL_PULSE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sec_wdt_rdmux #(
        .AW(AW), .DW(DW),
        .CNT_ADDR(CNT_ADDR), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
    ) rd_i (
        .addr  (reg_addr),
        .count (st_q.count),
        .ctrl  (st_q.ctrl),
        .stat  (st_q.stat),
        .rdata (reg_rdata)
    );

    assign wdt_out_n = ~st_q.stat[ST_TRIG_BIT];
    assign kbrst_n   = ~st_q.kbrst;
endmodule

// File: rtl/sec_watchdog_chk.sv
module sec_watchdog_chk #(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] CNT_ADDR = 'hF6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [AW-1:0] reg_addr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] count,
    input logic          unit_tick,
    input logic          cancel,
    input logic          wdt_out_n,
    input logic          kbrst_n
);
    logic wr_cnt;
    assign wr_cnt = reg_wr && (reg_addr == CNT_ADDR);

    // R1
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !wr_cnt) |=> (count == '0));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (count == $past(reg_wdata)));

    // R3
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0 && !wr_cnt && !cancel && unit_tick) |=> (count == $past(count) - 1'b1));

    // R5
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == DW'(1) && unit_tick && !wr_cnt && !cancel) |=> !wdt_out_n);

    // R6
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kbrst_n |=> kbrst_n);

    // R6
    pulse_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kbrst_n |-> !wdt_out_n);

    // R8
    cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !wr_cnt) |=> (count == '0));
endmodule

bind sec_watchdog sec_watchdog_chk #(.AW(AW), .DW(DW), .CNT_ADDR(CNT_ADDR)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .count     (st_q.count),
    .unit_tick (unit_tick),
    .cancel    (cancel),
    .wdt_out_n (wdt_out_n),
    .kbrst_n   (kbrst_n)
);

// File: tb/sec_watchdog_tb.sv
module sec_watchdog_tb_top;
    localparam logic [7:0] A_CNT  = 8'hF6;
    localparam logic [7:0] A_CTRL = 8'hF5;
    localparam logic [7:0] A_STAT = 8'hF7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
    logic       reg_wr = 1'b0, sec_tick = 1'b0, kbd_evt = 1'b0, mouse_evt = 1'b0;
    logic       wdt_out_n, kbrst_n;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    sec_watchdog dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .sec_tick(sec_tick),
        .kbd_evt(kbd_evt), .mouse_evt(mouse_evt),
        .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        check(req, int'(v), exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        rd_check("R9 count", A_CNT, 0);
        rd_check("R9 ctrl", A_CTRL, 0);
        rd_check("R9 stat", A_STAT, 0);
        check("R9 wdt_out_n", int'(wdt_out_n), 1);
        check("R9 kbrst_n", int'(kbrst_n), 1);

        // R3 R5 sweep of load values, no pulse enabled (R6 off case)
        for (int n = 1; n <= 12; n++) begin
            wr(A_CNT, 8'(n));
            rd_check("R2 load", A_CNT, n);
            for (int k = 1; k <= n; k++) begin
                tick();
                rd_check("R3 countdown", A_CNT, n - k);
                check("R5 out", int'(wdt_out_n), (k == n) ? 0 : 1);
                check("R6 no pulse", int'(kbrst_n), 1);
            end
            tick();
            check("R5 hold", int'(wdt_out_n), 0);
            wr(A_STAT, 8'h10);
            check("R7 write1 keeps", int'(wdt_out_n), 0);
            wr(A_STAT, 8'h00);
            check("R7 clear", int'(wdt_out_n), 1);
        end

        // R6 pulse
        wr(A_CTRL, 8'h02);
        rd_check("R4 ctrl rb", A_CTRL, 2);
        wr(A_CNT, 8'd2);
        tick();
        check("R6 before", int'(kbrst_n), 1);
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
        check("R6 low", int'(kbrst_n), 0);
        check("R5 flag", int'(wdt_out_n), 0);
        @(negedge clk);
        check("R6 one clock", int'(kbrst_n), 1);
        wr(A_STAT, 8'h00);
        wr(A_CTRL, 8'h00);

        // R2 keep-alive
        wr(A_CNT, 8'd5);
        repeat (3) tick();
        rd_check("R3 mid", A_CNT, 2);
        wr(A_CNT, 8'd5);
        rd_check("R2 reload", A_CNT, 5);
        repeat (4) tick();
        rd_check("R2 after reload", A_CNT, 1);
        check("R2 no expiry", int'(wdt_out_n), 1);

        // R1 stop
        wr(A_CNT, 8'd0);
        repeat (5) tick();
        rd_check("R1 stopped", A_CNT, 0);
        check("R1 no timeout", int'(wdt_out_n), 1);

        // R4 other address
        rd_check("R4 unmapped", 8'h20, 0);

        // R8 cancels
        wr(A_CNT, 8'd9);
        @(negedge clk); kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
        rd_check("R8 kbd ignored", A_CNT, 9);
        @(negedge clk); mouse_evt = 1'b1; @(negedge clk); mouse_evt = 1'b0;
        rd_check("R8 mouse ignored", A_CNT, 9);
        wr(A_STAT, 8'h80);
        rd_check("R4 stat rb", A_STAT, 8'h80);
        @(negedge clk); kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
        rd_check("R8 kbd status cancel", A_CNT, 0);
        wr(A_STAT, 8'h40);
        wr(A_CNT, 8'd9);
        @(negedge clk); kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
        rd_check("R8 kbd off", A_CNT, 9);
        @(negedge clk); mouse_evt = 1'b1; @(negedge clk); mouse_evt = 1'b0;
        rd_check("R8 mouse cancel", A_CNT, 0);
        wr(A_STAT, 8'h00);
        wr(A_CTRL, 8'h04);
        wr(A_CNT, 8'd9);
        @(negedge clk); kbd_evt = 1'b1; @(negedge clk); kbd_evt = 1'b0;
        rd_check("R8 kbd ctrl cancel", A_CNT, 0);
        wr(A_CTRL, 8'h00);

        // R11 write collides with tick
        wr(A_CNT, 8'd1);
        @(negedge clk);
        reg_addr = A_CNT; reg_wdata = 8'd7; reg_wr = 1'b1; sec_tick = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; sec_tick = 1'b0;
        rd_check("R11 write wins", A_CNT, 7);
        check("R11 no expiry", int'(wdt_out_n), 1);
        wr(A_CNT, 8'd0);

        // R10 minute mode
        wr(A_CTRL, 8'h08);
        wr(A_CNT, 8'd2);
        repeat (59) tick();
        rd_check("R10 59 ticks", A_CNT, 2);
        tick();
        rd_check("R10 60 ticks", A_CNT, 1);
        repeat (30) tick();
        wr(A_CNT, 8'd2);
        repeat (59) tick();
        rd_check("R10 restart", A_CNT, 2);
        repeat (61) tick();
        rd_check("R10 120 ticks", A_CNT, 0);
        check("R10 expiry", int'(wdt_out_n), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule